// File: doc/BRIEF.md
# Per-Processor Interrupt Pending Register

This block holds the 32-bit interrupt pending word for one processor. It also produces the registered 16-bit priority-level request vector that drives that processor's interrupt inputs. The pending word gathers four kinds of source:

- software interrupts, which are set and cleared over a small word-addressed bus window;
- a processor-local timer request, which follows a level input;
- a level-15 request broadcast to all processors, captured on its edges;
- a mirror of the routed device priority levels, kept only while this processor is the selected target.

Software reads the pending word at word offset 0. It clears bits through offset 1 and raises software bits through offset 2, and each of these two writes has its own mask. The request vector folds the software bits down onto levels 15:1 at all times. The timer, broadcast and device levels reach the vector only while the master-disable input is low.

Top module: `cpu_irq_pend`

## Requirements
- R1: While reset is asserted, and right after it is released, the pending word reads 0 and the level vector `irl` is 0.
- R2: A read at word offset 0 (byte address bits [3:2] = 0) returns the full pending word. A read at any other word offset returns 0.
- R3: A write to word offset 1 clears the pending bits that are set in the write data, within bits 31:17 and bit 15 only. Bit 14 and bits 13:1 are unchanged by it.
- R4: A write to word offset 2 sets the pending bits that are set in the write data, within bits 31:17 only. Bits 16:0, bit 15 included, are never set by software.
- R5: Pending bit 14 equals the timer request input as sampled at the previous clock edge.
- R6: Pending bit 15 is set at the edge that first sees the broadcast input high, and cleared at the edge that first sees it low. A clear write with data bit 15 set also clears it, and it then stays clear while the broadcast stays high.
- R7: Pending bits 13:1 equal the device level input bits 13:1 when `is_target` was high at the last edge, and 0 otherwise. Pending bits 16 and 0 are always 0.
- R8: Level bits 15:1 of `irl` always include pending bits 31:17 shifted right by 16, whatever the value of `master_dis`.
- R9: With `master_dis` low, `irl[15:1]` also includes pending bits 15:1. With it high, those bits add nothing. `irl[0]` is always 0.
- R10: `irl` is registered: it reflects the pending word and `master_dis` as they stood one clock edge earlier.
- R11: Byte address bits 1:0 are ignored on both reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_rdata | output | 32 | Combinational read data |
| timer_req | input | 1 | Processor-local timer request level |
| bcast15 | input | 1 | Broadcast level-15 request level |
| dev_lvl | input | 13 | Routed device priority levels 13:1 |
| is_target | input | 1 | This processor is the selected device target |
| master_dis | input | 1 | Master disable for non-software levels |
| irl | output | 16 | Registered priority-level request vector |

## Verification
A wrong pending bit shows at the read port as soon as offset 0 is read. It reaches `irl` one edge after the pending register takes it. A bit captured late or early is therefore caught by comparing `bus_rdata` one cycle after the stimulus and `irl` one cycle after that. Mask errors in the set or clear paths appear at once in the word read back after the write. A missing gate on `master_dis` appears as an `irl` level that stays high one cycle after the disable is raised.

// File: rtl/cpu_irq_pend.sv
module cpu_irq_pend #(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  input  logic              timer_req,
  input  logic              bcast15,
  input  logic [13:1]       dev_lvl,
  input  logic              is_target,
  input  logic              master_dis,
  output logic [15:0]       irl
);
  localparam int OFF_W = ADDR_W - 2;
  localparam logic [OFF_W-1:0] OFF_RD  = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_CLR = OFF_W'(1);
  localparam logic [OFF_W-1:0] OFF_SET = OFF_W'(2);

  logic [31:0] pend_q;
  logic [15:0] irl_q;
  logic        bc_q;

  wire [OFF_W-1:0] woff = bus_addr[ADDR_W-1:2];
  wire wr_clr = bus_we && (woff == OFF_CLR);
  wire wr_set = bus_we && (woff == OFF_SET);
  wire bc_rise = bcast15 && !bc_q;
  wire bc_fall = !bcast15 && bc_q;

  wire [14:0] sw_clr = wr_clr ? bus_wdata[31:17] : 15'h0;
  wire [14:0] sw_set = wr_set ? bus_wdata[31:17] : 15'h0;
  wire [14:0] sw_nxt = (pend_q[31:17] & ~sw_clr) | sw_set;
  wire        b15_nxt = bc_rise ? 1'b1
                      : (bc_fall || (wr_clr && bus_wdata[15])) ? 1'b0
                      : pend_q[15];
  wire [13:1] dev_nxt = is_target ? dev_lvl : 13'h0;

  wire [15:0] irl_nxt = {pend_q[31:17], 1'b0}
                      | (master_dis ? 16'h0 : {pend_q[15:1], 1'b0});

  wire unused_bits = ^{bus_addr[1:0], bus_wdata[16], bus_wdata[14:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 32'h0;
      irl_q  <= 16'h0;
      bc_q   <= 1'b0;
    end else begin
      pend_q <= {sw_nxt, 1'b0, b15_nxt, timer_req, dev_nxt, 1'b0};
      irl_q  <= irl_nxt;
      bc_q   <= bcast15;
    end
  end

  assign bus_rdata = (woff == OFF_RD) ? pend_q : 32'h0;
  assign irl       = irl_q;
endmodule

// File: rtl/cpu_irq_pend_chk.sv
module cpu_irq_pend_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:17]      wsw,
  input logic              bus_we,
  input logic              timer_req,
  input logic              is_target,
  input logic              master_dis,
  input logic [31:0]       pend,
  input logic [15:0]       irl
);
  wire [ADDR_W-3:0] off = bus_addr[ADDR_W-1:2];
  wire unused_lo = ^bus_addr[1:0];

  p_level0_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irl[0] == 1'b0);

  p_fold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irl[15:1] & $past(pend[31:17])) == $past(pend[31:17])));

  p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    master_dis |=> (irl[15:1] == $past(pend[31:17])));

  p_timer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pend[14] == $past(timer_req)));

  p_nontarget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !is_target |=> (pend[13:1] == 13'h0));

  p_fixed_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[16] == 1'b0) && (pend[0] == 1'b0));

  p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && off == (ADDR_W-2)'(2)) |=>
      (pend[31:17] == ($past(pend[31:17]) | $past(wsw))));
endmodule

bind cpu_irq_pend cpu_irq_pend_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wsw(bus_wdata[31:17]),
  .bus_we(bus_we), .timer_req(timer_req), .is_target(is_target),
  .master_dis(master_dis), .pend(pend_q), .irl(irl)
);

// File: tb/cpu_irq_pend_tb.sv
module cpu_irq_pend_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        timer_req = 1'b0;
  logic        bcast15 = 1'b0;
  logic [13:1] dev_lvl = 13'h0;
  logic        is_target = 1'b0;
  logic        master_dis = 1'b0;
  logic [15:0] irl;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  cpu_irq_pend #(.ADDR_W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .timer_req(timer_req),
    .bcast15(bcast15), .dev_lvl(dev_lvl), .is_target(is_target),
    .master_dis(master_dis), .irl(irl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    step();
    bus_we = 1'b0; bus_addr = 4'h0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 4'h0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 pend in reset", d, 32'h0);
    chk("R1 irl in reset", {16'h0, irl}, 32'h0);
    rst_n = 1'b1; step();
    rd(4'h0, d); chk("R1 pend after reset", d, 32'h0);
    chk("R1 irl after reset", {16'h0, irl}, 32'h0);
  endtask

  task automatic t_sw_set();
    logic [31:0] d;
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R4 set mask", d, 32'hFFFE_0000);
    chk("R10 irl lags one edge", {16'h0, irl}, 32'h0);
    step(); chk("R8 fold of sw bits", {16'h0, irl}, 32'h0000_FFFE);
    master_dis = 1'b1; step(); step();
    chk("R8 fold under master_dis", {16'h0, irl}, 32'h0000_FFFE);
    master_dis = 1'b0;
  endtask

  task automatic t_sw_clear();
    logic [31:0] d;
    wr(4'h4, 32'h8002_0000);
    rd(4'h0, d); chk("R3 partial clear", d, 32'h7FFC_0000);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R3 full clear", d, 32'h0);
    step(); chk("R10 irl after clear", {16'h0, irl}, 32'h0);
  endtask

  task automatic t_timer();
    logic [31:0] d;
    timer_req = 1'b1; step();
    rd(4'h0, d); chk("R5 timer sets bit14", d, 32'h0000_4000);
    step(); chk("R9 timer level enabled", {16'h0, irl}, 32'h0000_4000);
    master_dis = 1'b1; step();
    chk("R9 timer level gated", {16'h0, irl}, 32'h0);
    wr(4'h4, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R3 clear leaves bit14", d, 32'h0000_4000);
    master_dis = 1'b0; timer_req = 1'b0; step();
    rd(4'h0, d); chk("R5 timer low clears bit14", d, 32'h0);
  endtask

  task automatic t_bcast();
    logic [31:0] d;
    bcast15 = 1'b1; step();
    rd(4'h0, d); chk("R6 rising sets bit15", d, 32'h0000_8000);
    step(); chk("R9 bit15 level", {16'h0, irl}, 32'h0000_8000);
    wr(4'h4, 32'h0000_8000);
    rd(4'h0, d); chk("R6 sw clear of bit15", d, 32'h0);
    step(); rd(4'h0, d); chk("R6 stays clear while held", d, 32'h0);
    wr(4'h8, 32'h0001_8000);
    rd(4'h0, d); chk("R4 sw cannot set bit15/16", d, 32'h0);
    bcast15 = 1'b0; step(); bcast15 = 1'b1; step();
    rd(4'h0, d); chk("R6 new rising sets", d, 32'h0000_8000);
    bcast15 = 1'b0; step();
    rd(4'h0, d); chk("R6 falling clears", d, 32'h0);
  endtask

  task automatic t_dev();
    logic [31:0] d;
    dev_lvl = 13'h1555; is_target = 1'b0; step();
    rd(4'h0, d); chk("R7 non-target zero", d, 32'h0);
    is_target = 1'b1; step();
    rd(4'h0, d); chk("R7 target mirror", d, 32'h0000_2AAA);
    step(); chk("R9 device levels", {16'h0, irl}, 32'h0000_2AAA);
    master_dis = 1'b1; step();
    chk("R9 device levels gated", {16'h0, irl}, 32'h0);
    master_dis = 1'b0; is_target = 1'b0; step();
    rd(4'h0, d); chk("R7 deselect clears", d, 32'h0);
    dev_lvl = 13'h0;
  endtask

  task automatic t_offsets();
    logic [31:0] d;
    wr(4'h9, 32'h0006_0000);
    rd(4'h0, d); chk("R11 write ignores low bits", d, 32'h0006_0000);
    rd(4'h3, d); chk("R11 read ignores low bits", d, 32'h0006_0000);
    rd(4'h4, d); chk("R2 offset1 reads zero", d, 32'h0);
    rd(4'h8, d); chk("R2 offset2 reads zero", d, 32'h0);
    rd(4'hC, d); chk("R2 offset3 reads zero", d, 32'h0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R2 offset3 write no effect", d, 32'h0006_0000);
    wr(4'h6, 32'hFFFF_FFFF);
    rd(4'h0, d); chk("R11 clear ignores low bits", d, 32'h0);
  endtask

  initial begin
    repeat (3) step();
    t_reset();
    t_sw_set();
    t_sw_clear();
    t_timer();
    t_bcast();
    t_dev();
    t_offsets();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule